// File: doc/BRIEF.md
# Triple-Buffer Stream Controller

This controller lets a sample stream run without gaps while a separate engine works on whole blocks of that stream in repeated passes. Three equal memory banks are kept per input channel. At any moment one bank is written from the incoming stream, one belongs to the processing engine for as many passes as it needs, and one is read back out to the output stream. Every sample strobe writes the filling bank and reads the draining bank at the same slot address. On the strobe that fills the last slot, all three roles move on at once.

The banks themselves sit outside the block. The controller drives the slot address, the bank selects and the enables. It sends a one-cycle start pulse to the engine each time a fresh block is handed over, and it takes a done pulse back. A sample written into slot i comes out of slot i exactly two blocks (2·DEPTH strobes) later. The output is held at zero until the draining bank holds real data. If the engine has not reported done when the next handover is due, a sticky overrun flag is raised, and the rotation still goes ahead.

Top module: `tribuf_ctrl`

## Requirements
- R1: During and right after reset: slot address 0, filling bank 0, draining bank 1, processing bank 2, start pulse low, overrun low, output sample 0.
- R2: Each cycle with the sample strobe high advances the slot address by one. The strobe at slot DEPTH−1 wraps the address to 0. Without a strobe the address holds. The write and read addresses are always equal.
- R3: The strobe at slot DEPTH−1 rotates the roles: the filling bank becomes the processing bank, the processing bank becomes the draining bank, and the draining bank becomes the filling bank. The new selects are visible from the next cycle. The mapping always holds: draining = (filling+1) mod 3 and processing = (filling+2) mod 3.
- R4: The start pulse is high for exactly the one cycle after each rotating strobe, and low otherwise.
- R5: Write enable and read enable both follow the sample strobe in the same cycle.
- R6: The output sample is 0 until two rotations have completed since reset.
- R7: At each rotation other than the first after reset, the overrun flag is set if no done pulse arrived since the previous rotation (a done in the rotating cycle counts). Once set, it stays set until reset.
- R8: The three bank selects are always pairwise different.
- R9: Once primed, the output sample during a strobe equals the value written 2·DEPTH strobes earlier. This makes the latency a fixed two blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe per input/output sample |
| proc_done | input | 1 | Engine has finished the current block |
| mem_rdata | input | DATA_W | Data read from the draining bank at rd_addr |
| wr_en | output | 1 | Write enable for the filling bank |
| wr_addr | output | AW | Slot address for the write |
| fill_bank | output | 2 | Select of the filling bank |
| rd_en | output | 1 | Read enable for the draining bank |
| rd_addr | output | AW | Slot address for the read |
| drain_bank | output | 2 | Select of the draining bank |
| proc_bank | output | 2 | Select of the bank owned by the engine |
| blk_start | output | 1 | Start pulse to the engine |
| overrun | output | 1 | Sticky flag: engine missed a handover |
| out_sample | output | DATA_W | Output stream sample, gated to 0 until primed |

## Verification
The enables and the output sample are combinational, so they are checked one time step after the inputs are driven, before the clock edge. The slot address, bank selects, start pulse and overrun flag are registered, so they are checked just after the edge that takes the strobe in. The table rows encode this one-edge delay. The latency test keeps its own record of every written value and looks up the output 2·DEPTH strobes later, taking it while the strobe is still high in that cycle.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
  typedef logic [1:0] bank_t;

  // bank that a given bank hands over to on rotation (0 -> 1 -> 2 -> 0)
  function automatic bank_t bank_after(input bank_t b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

  function automatic bank_t drain_of(input bank_t fill);
    return bank_after(fill);
  endfunction

  function automatic bank_t proc_of(input bank_t fill);
    return bank_after(bank_after(fill));
  endfunction
endpackage

// File: rtl/tribuf_slot_ctr.sv
module tribuf_slot_ctr #(
  parameter int DEPTH = 2500,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] idx,
  output logic          at_last
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign at_last = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx <= '0;
    else if (step && at_last)  idx <= '0;
    else if (step)             idx <= idx + 1'b1;
  end
endmodule

// File: rtl/tribuf_role_rot.sv
module tribuf_role_rot
  import tribuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rotate,
  output bank_t fill,
  output bank_t proc,
  output bank_t drain
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill <= 2'd0;
    else if (rotate) fill <= bank_after(fill);
  end

  assign drain = drain_of(fill);
  assign proc  = proc_of(fill);
endmodule

// File: rtl/tribuf_guard.sv
module tribuf_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic rotate,
  input  logic proc_done,
  output logic blk_start,
  output logic overrun,
  output logic primed
);
  logic [1:0] rot_cnt;   // saturates at 2
  logic       done_seen;
  logic       armed;

  assign armed  = (rot_cnt != 2'd0);
  assign primed = (rot_cnt == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_cnt   <= 2'd0;
      done_seen <= 1'b0;
      overrun   <= 1'b0;
      blk_start <= 1'b0;
    end else begin
      blk_start <= rotate;
      if (rotate) begin
        if (!primed) rot_cnt <= rot_cnt + 2'd1;
        if (armed && !(done_seen || proc_done)) overrun <= 1'b1;
        done_seen <= 1'b0;
      end else if (proc_done) begin
        done_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tribuf_ctrl.sv
module tribuf_ctrl
  import tribuf_pkg::*;
#(
  parameter int DEPTH  = 2500,
  parameter int DATA_W = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              proc_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [1:0]        fill_bank,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic [1:0]        drain_bank,
  output logic [1:0]        proc_bank,
  output logic              blk_start,
  output logic              overrun,
  output logic [DATA_W-1:0] out_sample
);
  logic [AW-1:0] slot;
  logic          last_slot;
  logic          rot_evt;
  logic          primed;
  bank_t         fill_w, proc_w, drain_w;

  tribuf_slot_ctr #(.DEPTH(DEPTH), .AW(AW)) u_slot (
    .clk(clk), .rst_n(rst_n), .step(smp_stb), .idx(slot), .at_last(last_slot)
  );

  assign rot_evt = smp_stb && last_slot;

  tribuf_role_rot u_rot (
    .clk(clk), .rst_n(rst_n), .rotate(rot_evt),
    .fill(fill_w), .proc(proc_w), .drain(drain_w)
  );

  tribuf_guard u_guard (
    .clk(clk), .rst_n(rst_n), .rotate(rot_evt), .proc_done(proc_done),
    .blk_start(blk_start), .overrun(overrun), .primed(primed)
  );

  assign wr_en      = smp_stb;
  assign rd_en      = smp_stb;
  assign wr_addr    = slot;
  assign rd_addr    = slot;
  assign fill_bank  = fill_w;
  assign drain_bank = drain_w;
  assign proc_bank  = proc_w;
  assign out_sample = primed ? mem_rdata : '0;
endmodule

// File: rtl/tribuf_ctrl_chk.sv
module tribuf_ctrl_chk
  import tribuf_pkg::*;
#(
  parameter int DEPTH  = 2500,
  parameter int DATA_W = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic [AW-1:0]     wr_addr,
  input logic [1:0]        fill_bank,
  input logic [1:0]        proc_bank,
  input logic [1:0]        drain_bank,
  input logic              blk_start,
  input logic              overrun,
  input logic [DATA_W-1:0] out_sample,
  input logic              rot_evt,
  input logic              last_slot
);
  logic [1:0] seen_rot;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seen_rot <= 2'd0;
    else if (rot_evt && seen_rot != 2'd2) seen_rot <= seen_rot + 2'd1;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && !last_slot |=> wr_addr == $past(wr_addr) + 1'b1); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(wr_addr)); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rot_evt |=> wr_addr == '0); // R2
  AST_ROLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    rot_evt |=> fill_bank == bank_after($past(fill_bank)) && proc_bank == $past(fill_bank)); // R3
  AST_ROLE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_evt |=> $stable(fill_bank)); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rot_evt |=> blk_start); // R4
  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_evt |=> !blk_start); // R4
  AST_OUT_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    seen_rot != 2'd2 |-> out_sample == '0); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bank != drain_bank && fill_bank != proc_bank && drain_bank != proc_bank); // R8
endmodule

bind tribuf_ctrl tribuf_ctrl_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .wr_addr(wr_addr),
  .fill_bank(fill_bank), .proc_bank(proc_bank), .drain_bank(drain_bank),
  .blk_start(blk_start), .overrun(overrun), .out_sample(out_sample),
  .rot_evt(rot_evt), .last_slot(last_slot)
);

// File: tb/sim_tribuf_ctrl.sv
module sim_tribuf_ctrl;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 16;
  localparam int AW     = $clog2(DEPTH);
  localparam int NROW   = 20;
  // row = {stb, done, exp_addr[1:0], exp_fill[1:0], exp_start, exp_ovr}
  localparam logic [7:0] VEC [NROW] = '{
    8'b10010000, 8'b00010000, 8'b10100000, 8'b10110000, 8'b10000110,
    8'b01000100, 8'b10010100, 8'b10100100, 8'b10110100, 8'b10001010,
    8'b10011000, 8'b10101000, 8'b10111000, 8'b11000010, 8'b10010000,
    8'b10100000, 8'b10110000, 8'b10000111, 8'b01000101, 8'b10010101
  };

  logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0, proc_done = 1'b0;
  logic [DATA_W-1:0] mem_rdata, wdata = '0, out_sample;
  logic wr_en, rd_en, blk_start, overrun;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [1:0] fill_bank, drain_bank, proc_bank;
  logic [DATA_W-1:0] mem [3*DEPTH];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  tribuf_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .proc_done(proc_done),
    .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_addr(wr_addr), .fill_bank(fill_bank),
    .rd_en(rd_en), .rd_addr(rd_addr), .drain_bank(drain_bank), .proc_bank(proc_bank),
    .blk_start(blk_start), .overrun(overrun), .out_sample(out_sample)
  );

  // bench-side bank memory
  always @(posedge clk) if (wr_en) mem[int'(fill_bank)*DEPTH + int'(wr_addr)] <= wdata;
  assign mem_rdata = mem[int'(drain_bank)*DEPTH + int'(rd_addr)];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check_reset_state();
    check("R1 addr", int'(wr_addr), 0);
    check("R1 fill", int'(fill_bank), 0);
    check("R1 drain", int'(drain_bank), 1);
    check("R1 proc", int'(proc_bank), 2);
    check("R1 start", int'(blk_start), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 out", int'(out_sample), 0);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check_reset_state();                         // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    #1 check_reset_state();                         // R1 after release

    // table walk: R2 R3 R4 R5 R7 R8
    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      smp_stb = VEC[r][7]; proc_done = VEC[r][6];
      #1;
      check("R5 wr_en", int'(wr_en), int'(VEC[r][7]));
      check("R5 rd_en", int'(rd_en), int'(VEC[r][7]));
      @(posedge clk); #1;
      check("R2 addr", int'(wr_addr), int'(VEC[r][5:4]));
      check("R2 rd=wr", int'(rd_addr), int'(wr_addr));
      check("R3 fill", int'(fill_bank), int'(VEC[r][3:2]));
      check("R3 drain", int'(drain_bank), (int'(VEC[r][3:2]) + 1) % 3);
      check("R3 proc", int'(proc_bank), (int'(VEC[r][3:2]) + 2) % 3);
      check("R8 distinct", int'(fill_bank != drain_bank && drain_bank != proc_bank
                                && fill_bank != proc_bank), 1);
      check("R4 start", int'(blk_start), int'(VEC[r][1]));
      check("R7 overrun", int'(overrun), int'(VEC[r][0]));
    end
    @(negedge clk) smp_stb = 1'b0; proc_done = 1'b0;

    // reset in the middle of a block clears everything, including overrun
    @(negedge clk) rst_n = 1'b0;
    #1 check_reset_state();                         // R1 mid-run reset
    @(negedge clk) rst_n = 1'b1;

    // latency stream: R6 muting, R9 two-block delay, R7 no false flag
    for (int j = 0; j < 5 * DEPTH; j++) begin
      @(negedge clk);
      smp_stb = 1'b1; wdata = 16'hA000 + 16'(j); proc_done = (j % DEPTH == 1);
      #1;
      if (j < 2 * DEPTH) check("R6 muted out", int'(out_sample), 0);
      else check("R9 delayed out", int'(out_sample), int'(16'hA000 + 16'(j - 2 * DEPTH)));
      @(posedge clk);
    end
    @(negedge clk) smp_stb = 1'b0; proc_done = 1'b0;
    #1 check("R7 no overrun when done on time", int'(overrun), 0);
    finish_run();
  end
endmodule